// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block decodes the write cycles that a host issues to a word-wide flash-style memory. Every instruction begins with the same two-cycle protective key. The third cycle then names the instruction. Array reads, signature reads, word programming and whole-chip erase are all entered this way. Program needs one more cycle, which carries the target address and data. Erase needs a second copy of the key and then a confirm word. Any write that breaks the expected order puts the interface back in array-read mode.

Once an operation starts, the block is busy for a fixed number of clocks set by a parameter. During that time every read returns a status word instead of array data. The status word has a data-polling flag and a pair of bits that alternate on each read. All writes made while busy are dropped. When the operation ends, the storage is updated and the interface returns to array reads.

The storage is a behavioural model. Its depth is set by a parameter, and the low address bits select the word, so the 16-bit bus address space aliases onto it. Reads are registered: the data appears one clock after the read strobe, with a valid flag.

States: `ST_READ`, `ST_ASEL`, `ST_UNL1`, `ST_UNL2`, `ST_PGM_ARM`, `ST_ERS_ARM`, `ST_ERS_UNL1`, `ST_ERS_UNL2`, `ST_BUSY_PGM`, `ST_BUSY_ERS`.

Transitions, each taken on a write:
- key-1 (0x00AA at 0x5555) moves READ/ASEL to UNL1, and moves ERS_ARM to ERS_UNL1.
- key-2 (0x0055 at 0x2AAA) moves UNL1 to UNL2, and moves ERS_UNL1 to ERS_UNL2.
- From UNL2, a write at 0x5555 selects the next state by its data:
  - 0x0090 goes to ASEL.
  - 0x00A0 goes to PGM_ARM.
  - 0x0080 goes to ERS_ARM.
  - 0x00F0, or any other value, goes to READ.
- Any write in PGM_ARM goes to BUSY_PGM.
- In ERS_UNL2, 0x0010 at 0x5555 goes to BUSY_ERS.
- Any mismatching write goes to READ.
- Timer expiry moves BUSY_* to READ.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy` and `rd_valid` are 0 and every word of the storage reads 0xFFFF.
- R2: A read strobe in one cycle gives `rd_valid`=1 in the next cycle, with `rd_data` holding the value selected in the strobe cycle. When there is no strobe, `rd_valid` is 0.
- R3: An instruction is accepted only if it is preceded by 0x00AA written at 0x5555 and then 0x0055 written at 0x2AAA. If the key is wrong, the following command is not carried out.
- R4: After the key and then 0x0090 written at 0x5555, reads return signature words chosen by address bits [1:0]: 00 gives MFR_CODE, 01 gives DEV_CODE, and any other value gives 0x0000. The next write that is not key-1 returns the block to array reads.
- R5: After the key, 0x00A0 written at 0x5555 and then one write of address and data, the addressed word becomes its old value AND the data once the operation ends.
- R6: After the key, 0x0080 at 0x5555, the key again and then 0x0010 at 0x5555, every word reads 0xFFFF once the operation ends.
- R7: An unrecognised set-up code, or a wrong erase confirm, returns the block to array reads and leaves the storage unchanged without starting an operation.
- R8: `busy` rises in the cycle after the write that completes a sequence and stays high for exactly BUSY_CYCLES cycles.
- R9: Status bit 7 is the complement of data bit 7 during program and 0 during erase. Status bits 15:8, 5:3 and 1:0 are 0.
- R10: Status bits 6 and 2 are always equal to each other. They read 0 on the first status read of an operation and invert on each further status read.
- R11: Writes made while busy are ignored. A read in the last busy cycle returns status, and the next read returns the updated array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wdata | input | DATA_W | Write data / command word |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_re | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read result |
| rd_valid | output | 1 | rd_data carries a new result |
| busy | output | 1 | Program or erase in progress |

## Verification
Completion of an operation and a host access can fall in the same cycle: the timer expires at the same edge that captures a read, or a write. The bench provokes this by counting clocks from the write that completes a program. It then asserts a read and a write together in the final busy cycle. It judges the outcome in three ways:
- The read must come back as a status word with the polling flag and toggle bits expected for that operation.
- `busy` must be low one cycle later.
- A following array read must show the programmed value, untouched by the write made in that last cycle.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_ASEL,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_ARM,
        ST_ERS_ARM,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_BUSY_PGM,
        ST_BUSY_ERS
    } fcs_state_e;

    localparam logic [15:0] KEY1_ADDR   = 16'h5555;
    localparam logic [15:0] KEY1_DATA   = 16'h00AA;
    localparam logic [15:0] KEY2_ADDR   = 16'h2AAA;
    localparam logic [15:0] KEY2_DATA   = 16'h0055;
    localparam logic [15:0] CMD_RESET   = 16'h00F0;
    localparam logic [15:0] CMD_ASEL    = 16'h0090;
    localparam logic [15:0] CMD_PGM     = 16'h00A0;
    localparam logic [15:0] CMD_ERS     = 16'h0080;
    localparam logic [15:0] CMD_ERS_CFM = 16'h0010;

endpackage

// File: rtl/fcs_seq_fsm.sv
module fcs_seq_fsm
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              op_done,
    output fcs_state_e        state,
    output logic              start_pgm,
    output logic              start_ers,
    output logic              busy,
    output logic              in_asel,
    output logic              is_pgm,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data
);

    localparam logic [ADDR_W-1:0] A_KEY1 = ADDR_W'(KEY1_ADDR);
    localparam logic [ADDR_W-1:0] A_KEY2 = ADDR_W'(KEY2_ADDR);
    localparam logic [DATA_W-1:0] D_KEY1 = DATA_W'(KEY1_DATA);
    localparam logic [DATA_W-1:0] D_KEY2 = DATA_W'(KEY2_DATA);
    localparam logic [DATA_W-1:0] D_RST  = DATA_W'(CMD_RESET);
    localparam logic [DATA_W-1:0] D_ASEL = DATA_W'(CMD_ASEL);
    localparam logic [DATA_W-1:0] D_PGM  = DATA_W'(CMD_PGM);
    localparam logic [DATA_W-1:0] D_ERS  = DATA_W'(CMD_ERS);
    localparam logic [DATA_W-1:0] D_CFM  = DATA_W'(CMD_ERS_CFM);

    fcs_state_e nxt;
    logic       key1_hit;
    logic       key2_hit;
    logic       at_key1;

    assign key1_hit = (wr_addr == A_KEY1) && (wr_data == D_KEY1);
    assign key2_hit = (wr_addr == A_KEY2) && (wr_data == D_KEY2);
    assign at_key1  = (wr_addr == A_KEY1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_READ;
        end else begin
            state <= nxt;
        end
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_READ, ST_ASEL: begin
                if (wr_en) nxt = key1_hit ? ST_UNL1 : ST_READ;
            end
            ST_UNL1: begin
                if (wr_en) nxt = key2_hit ? ST_UNL2 : ST_READ;
            end
            ST_UNL2: begin
                if (wr_en) begin
                    if (!at_key1) begin
                        nxt = ST_READ;
                    end else if (wr_data == D_ASEL) begin
                        nxt = ST_ASEL;
                    end else if (wr_data == D_PGM) begin
                        nxt = ST_PGM_ARM;
                    end else if (wr_data == D_ERS) begin
                        nxt = ST_ERS_ARM;
                    end else if (wr_data == D_RST) begin
                        nxt = ST_READ;
                    end else begin
                        nxt = ST_READ;
                    end
                end
            end
            ST_PGM_ARM: begin
                if (wr_en) nxt = ST_BUSY_PGM;
            end
            ST_ERS_ARM: begin
                if (wr_en) nxt = key1_hit ? ST_ERS_UNL1 : ST_READ;
            end
            ST_ERS_UNL1: begin
                if (wr_en) nxt = key2_hit ? ST_ERS_UNL2 : ST_READ;
            end
            ST_ERS_UNL2: begin
                if (wr_en) nxt = (at_key1 && wr_data == D_CFM) ? ST_BUSY_ERS : ST_READ;
            end
            ST_BUSY_PGM, ST_BUSY_ERS: begin
                if (op_done) nxt = ST_READ;
            end
            default: nxt = ST_READ;
        endcase
    end

    // outputs
    always_comb begin
        start_pgm = 1'b0;
        start_ers = 1'b0;
        busy      = 1'b0;
        in_asel   = 1'b0;
        is_pgm    = 1'b0;
        unique case (state)
            ST_PGM_ARM:  start_pgm = wr_en;
            ST_ERS_UNL2: start_ers = wr_en && at_key1 && (wr_data == D_CFM);
            ST_BUSY_PGM: begin
                busy   = 1'b1;
                is_pgm = 1'b1;
            end
            ST_BUSY_ERS: busy    = 1'b1;
            ST_ASEL:     in_asel = 1'b1;
            default: ;
        endcase
    end

    // program operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pgm_addr <= '0;
            pgm_data <= '0;
        end else if (start_pgm) begin
            pgm_addr <= wr_addr;
            pgm_data <= wr_data;
        end
    end

endmodule

// File: rtl/fcs_busy_timer.sv
module fcs_busy_timer #(
    parameter int BUSY_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    output logic done
);

    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LOAD;
        end else if (active && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = active && (cnt == '0);

endmodule

// File: rtl/fcs_array.sv
module fcs_array #(
    parameter int ARR_AW = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_commit,
    input  logic              ers_commit,
    input  logic [ARR_AW-1:0] pgm_idx,
    input  logic [DATA_W-1:0] pgm_data,
    input  logic [ARR_AW-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ARR_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n || ers_commit) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (pgm_commit) begin
            mem[pgm_idx] <= mem[pgm_idx] & pgm_data;
        end
    end

    assign rd_word = mem[rd_idx];

endmodule

// File: rtl/fcs_read_mux.sv
module fcs_read_mux #(
    parameter int          DATA_W   = 16,
    parameter logic [15:0] MFR_CODE = 16'h0020,
    parameter logic [15:0] DEV_CODE = 16'h00D5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              busy,
    input  logic              is_pgm,
    input  logic              pgm_bit7,
    input  logic              in_asel,
    input  logic              rd_en,
    input  logic [1:0]        sig_sel,
    input  logic [DATA_W-1:0] arr_word,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic              tgl;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] sig_word;
    logic [DATA_W-1:0] sel_word;

    always_ff @(posedge clk) begin
        if (!rst_n || op_start) begin
            tgl <= 1'b0;
        end else if (busy && rd_en) begin
            tgl <= ~tgl;
        end
    end

    always_comb begin
        status    = '0;
        status[7] = is_pgm ? ~pgm_bit7 : 1'b0;
        status[6] = tgl;
        status[2] = tgl;
    end

    always_comb begin
        unique case (sig_sel)
            2'b00:   sig_word = DATA_W'(MFR_CODE);
            2'b01:   sig_word = DATA_W'(DEV_CODE);
            default: sig_word = '0;
        endcase
    end

    always_comb begin
        if (busy) begin
            sel_word = status;
        end else if (in_asel) begin
            sel_word = sig_word;
        end else begin
            sel_word = arr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= sel_word;
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 16,
    parameter int          ARR_AW      = 8,
    parameter int          BUSY_CYCLES = 20,
    parameter logic [15:0] MFR_CODE    = 16'h0020,
    parameter logic [15:0] DEV_CODE    = 16'h00D5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy
);

    fcs_state_e        state;
    logic              start_pgm;
    logic              start_ers;
    logic              op_done;
    logic              in_asel;
    logic              is_pgm;
    logic [ADDR_W-1:0] pgm_addr;
    logic [DATA_W-1:0] pgm_data;
    logic [DATA_W-1:0] arr_word;

    fcs_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we),
        .wr_addr   (bus_addr),
        .wr_data   (bus_wdata),
        .op_done   (op_done),
        .state     (state),
        .start_pgm (start_pgm),
        .start_ers (start_ers),
        .busy      (busy),
        .in_asel   (in_asel),
        .is_pgm    (is_pgm),
        .pgm_addr  (pgm_addr),
        .pgm_data  (pgm_data)
    );

    fcs_busy_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_pgm | start_ers),
        .active (busy),
        .done   (op_done)
    );

    fcs_array #(
        .ARR_AW (ARR_AW),
        .DATA_W (DATA_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .pgm_commit (op_done && (state == ST_BUSY_PGM)),
        .ers_commit (op_done && (state == ST_BUSY_ERS)),
        .pgm_idx    (pgm_addr[ARR_AW-1:0]),
        .pgm_data   (pgm_data),
        .rd_idx     (bus_addr[ARR_AW-1:0]),
        .rd_word    (arr_word)
    );

    fcs_read_mux #(
        .DATA_W   (DATA_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_rmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (start_pgm | start_ers),
        .busy     (busy),
        .is_pgm   (is_pgm),
        .pgm_bit7 (pgm_data[7]),
        .in_asel  (in_asel),
        .rd_en    (bus_re),
        .sig_sel  (bus_addr[1:0]),
        .arr_word (arr_word),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
    parameter int BUSY_CYCLES = 20,
    parameter int DATA_W      = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic              bus_re,
    input logic              busy,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data
);

    localparam int CW = $clog2(BUSY_CYCLES + 2);

    logic [CW-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            busy_run <= '0;
        end else begin
            busy_run <= busy_run + 1'b1;
        end
    end

    // R2: read strobe yields valid next cycle
    assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> rd_valid);

    // R2: no strobe, no valid
    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> !rd_valid);

    // R8: busy never outlasts its window
    assert_busy_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < CW'(BUSY_CYCLES)));

    // R8: busy starts only after a write
    assert_busy_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_we));

    // R9 / R10: status word shape
    assert_status_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(busy)) |->
            (rd_data[6] == rd_data[2]) && (rd_data[DATA_W-1:8] == '0) &&
            (rd_data[5:3] == 3'b000) && (rd_data[1:0] == 2'b00));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
    .BUSY_CYCLES (BUSY_CYCLES),
    .DATA_W      (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .busy     (busy),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

    localparam int          BC  = 20;
    localparam logic [15:0] MFR = 16'h0020;
    localparam logic [15:0] DEV = 16'h00D5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    flash_cmd_seq #(
        .BUSY_CYCLES (BC),
        .MFR_CODE    (MFR),
        .DEV_CODE    (DEV)
    ) u_flash_cmd_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .busy      (busy)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        bus_re   = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic key();
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(rd_data, 16'hxxxx, "R2 unexpected rd_valid");
            end else begin
                check(rd_data, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check({15'd0, busy}, 16'd0, "R1 busy after reset");
        check({15'd0, rd_valid}, 16'd0, "R1 rd_valid after reset");
        rst_n = 1'b1;
        rd(16'h0010, 16'hFFFF, "R1 erased after reset");
        rd(16'h00F3, 16'hFFFF, "R1 R2 erased word");

        // program with status polling (R5 R9 R10)
        key();
        wr(16'h5555, 16'h00A0);
        wr(16'h0010, 16'h5A3C);
        rd(16'h0010, 16'h0080, "R9 R10 status read 1");
        rd(16'h0010, 16'h00C4, "R10 status read 2");
        rd(16'h0010, 16'h0080, "R10 status read 3");
        wait_idle(n);
        rd(16'h0010, 16'h5A3C, "R5 programmed word");

        // program that only clears bits, busy length (R5 R8)
        key();
        wr(16'h5555, 16'h00A0);
        wr(16'h0010, 16'h0FF0);
        wait_idle(n);
        check(16'(n), 16'(BC), "R8 busy length");
        rd(16'h0010, 16'h0A30, "R5 AND of old and new");

        // wrong key (R3)
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAB, 16'h0055);
        wr(16'h5555, 16'h00A0);
        wr(16'h0010, 16'h0000);
        check({15'd0, busy}, 16'd0, "R3 no busy after bad key");
        rd(16'h0010, 16'h0A30, "R3 word untouched");

        // bad set-up code and bad erase confirm (R7)
        key();
        wr(16'h5555, 16'h0077);
        wr(16'h0010, 16'h0000);
        check({15'd0, busy}, 16'd0, "R7 no busy after bad code");
        rd(16'h0010, 16'h0A30, "R7 word untouched");
        key();
        wr(16'h5555, 16'h0080);
        key();
        wr(16'h5555, 16'h0030);
        check({15'd0, busy}, 16'd0, "R7 no erase on bad confirm");
        rd(16'h0010, 16'h0A30, "R7 word kept");

        // signature read (R4)
        key();
        wr(16'h5555, 16'h0090);
        rd(16'h0000, MFR, "R4 manufacturer code");
        rd(16'h0001, DEV, "R4 device code");
        rd(16'h0002, 16'h0000, "R4 other offset");
        wr(16'h0000, 16'h00F0);
        rd(16'h0010, 16'h0A30, "R4 back to array");

        // completion collides with read and write; mid-busy write ignored (R11)
        key();
        wr(16'h5555, 16'h00A0);
        wr(16'h0020, 16'h00FF);
        wr(16'h5555, 16'h00AA);
        repeat (BC - 3) @(negedge clk);
        check({15'd0, busy}, 16'd1, "R11 still busy in last cycle");
        bus_addr  = 16'h0020;
        bus_wdata = 16'h0000;
        bus_we    = 1'b1;
        bus_re    = 1'b1;
        exp_q.push_back(16'h0000);
        tag_q.push_back("R11 status in last busy cycle");
        @(negedge clk);
        bus_we = 1'b0;
        bus_re = 1'b0;
        check({15'd0, busy}, 16'd0, "R11 busy ended");
        wr(16'h2AAA, 16'h0055);
        wr(16'h5555, 16'h00A0);
        wr(16'h0020, 16'h0000);
        check({15'd0, busy}, 16'd0, "R11 busy-time write not kept");
        rd(16'h0020, 16'h00FF, "R11 R5 word after collision");

        // chip erase (R6 R9 R10)
        key();
        wr(16'h5555, 16'h0080);
        key();
        wr(16'h5555, 16'h0010);
        rd(16'h0010, 16'h0000, "R9 erase status 1");
        rd(16'h0010, 16'h0044, "R10 erase status 2");
        wait_idle(n);
        check(16'(n), 16'(BC - 4), "R8 erase busy remainder");
        rd(16'h0010, 16'hFFFF, "R6 word erased");
        rd(16'h0020, 16'hFFFF, "R6 second word erased");

        repeat (4) @(negedge clk);
        check(16'(exp_q.size()), 16'd0, "R2 all reads returned");
        finish_run();
    end

endmodule